// File: doc/BRIEF.md
# External Bus Chip-Select Decoder

This block decodes the address of each bus request against one programmable window on an external bus. It also sets the length of the access on that bus. Two configuration words are written through a one-cycle write port. The range word carries the window base in its upper 24 bits and a 4-bit size code in its low nibble. The control word carries the enable, the wait-state count, the peripheral width and the byte-order option.

A request is accepted only while the block is idle. An accepted request that falls inside an enabled window drives the chip select for one cycle plus the programmed wait states. The block then pulses a completion strobe with the hit flag set. A request that misses completes one cycle after acceptance without touching the chip select. For the whole access the block reports the data width and the byte-lane swap that were captured when the request was accepted.

Top module: `ext_cs_decoder`

## Requirements
- R1: After reset, cs_o, done_o and busy_o are low, and both configuration words are zero, so the first request misses.
- R2: When bit 0 of the control word is 0, no address matches; the request completes as a miss.
- R3: The range word holds the base in bits 31:8 and a size code k in bits 3:0. The window is 8 KB shifted left by k. An address hits when its bits from 13+k up to 31 equal the same bits of the base. Base bits below 13+k have no effect.
- R4: Size code 15 gives a 256 MB window, in which only address bits 31:28 are compared.
- R5: On a hit, cs_o is high for exactly 1 + W consecutive cycles, where W is bits 3:1 of the control word (0 to 7).
- R6: done_o pulses high for one cycle in the cycle right after cs_o falls, with hit_o high. busy_o is high from the cycle after acceptance through the done cycle, so a hit spans W + 2 busy cycles.
- R7: On a miss, cs_o stays low, and done_o pulses with hit_o low in the first cycle after acceptance, which is the only busy cycle.
- R8: wide_o reports control bit 4 (1 = 16-bit peripheral, 0 = 8-bit) and swap_o reports control bit 10 (byte order reversed). Both are captured at acceptance and hold steady through done_o.
- R9: req_valid_i is ignored while busy_o is high; such a request produces no access and no done_o.
- R10: Configuration writes made during an access do not change the wait count, width or swap of that access. They apply from the next accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 1 | 0 selects the range word, 1 the control word |
| cfg_wdata_i | input | 32 | Configuration write data |
| req_valid_i | input | 1 | Request strobe, sampled while idle |
| req_addr_i | input | 32 | Request address |
| busy_o | output | 1 | An access is in progress |
| cs_o | output | 1 | Chip select for the range |
| done_o | output | 1 | One-cycle completion strobe |
| hit_o | output | 1 | Completed request hit the window (valid with done_o) |
| wide_o | output | 1 | Captured width: 1 = 16-bit peripheral |
| swap_o | output | 1 | Captured byte-lane reversal |

## Verification
A corrupted wait counter shows up as a chip-select pulse of the wrong length. It also moves done_o, so the error appears at the end of that same access. A wrong compare mask or a stale size code turns a hit into a miss, or a miss into a hit, and done_o reveals this one cycle after acceptance through hit_o and the absence of cs_o. A state machine that fails to ignore requests while busy produces an extra done_o that no request accounts for. Attributes sampled at the wrong moment show up as wide_o or swap_o values that differ from the control word in force at acceptance.

// File: rtl/ext_cs_pkg.sv
package ext_cs_pkg;
  localparam int ADDR_W        = 32;
  localparam int BASE_LSB      = 8;
  localparam int MIN_WIN_LOG2  = 13;
  localparam int SIZE_W        = 4;
  localparam int WS_W          = 3;
  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_WS_LSB   = 1;
  localparam int CTRL_WIDE_BIT = 4;
  localparam int CTRL_SWAP_BIT = 10;

  typedef struct packed {
    logic            en;
    logic [WS_W-1:0] ws;
    logic            wide;
    logic            swap;
  } ctrl_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACC  = 2'd1,
    ST_DONE = 2'd2
  } acc_st_e;
endpackage

// File: rtl/ext_cs_cfg_regs.sv
module ext_cs_cfg_regs
  import ext_cs_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int BL = BASE_LSB,
  parameter int SW = SIZE_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic             sel_i,
  input  logic [AW-1:0]    wdata_i,
  output logic [AW-BL-1:0] base_hi_o,
  output logic [SW-1:0]    size_o,
  output ctrl_t            ctrl_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_hi_o <= '0;
      size_o    <= '0;
      ctrl_o    <= '0;
    end else if (we_i) begin
      if (!sel_i) begin
        base_hi_o <= wdata_i[AW-1:BL];
        size_o    <= wdata_i[SW-1:0];
      end else begin
        ctrl_o.en   <= wdata_i[CTRL_EN_BIT];
        ctrl_o.ws   <= wdata_i[CTRL_WS_LSB +: WS_W];
        ctrl_o.wide <= wdata_i[CTRL_WIDE_BIT];
        ctrl_o.swap <= wdata_i[CTRL_SWAP_BIT];
      end
    end
  end
endmodule

// File: rtl/ext_cs_addr_match.sv
module ext_cs_addr_match
  import ext_cs_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int BL = BASE_LSB,
  parameter int ML = MIN_WIN_LOG2,
  parameter int SW = SIZE_W
) (
  input  logic [AW-1:0]    addr_i,
  input  logic [AW-BL-1:0] base_hi_i,
  input  logic [SW-1:0]    size_i,
  input  logic             en_i,
  output logic             hit_o
);
  localparam int CMP_W = AW - ML;

  logic [CMP_W-1:0] bit_ok;
  logic [31:0]      win_log2;

  assign win_log2 = 32'(ML) + 32'(size_i);

  // bits below the window are don't-care, the rest must equal the base
  for (genvar b = ML; b < AW; b++) begin : g_bit
    assign bit_ok[b-ML] = (32'(b) < win_log2) || (addr_i[b] == base_hi_i[b-BL]);
  end

  assign hit_o = en_i && (&bit_ok);
endmodule

// File: rtl/ext_cs_access_fsm.sv
module ext_cs_access_fsm
  import ext_cs_pkg::*;
#(
  parameter int WW = WS_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  input  logic          hit_i,
  input  logic [WW-1:0] ws_i,
  input  logic          wide_i,
  input  logic          swap_i,
  output logic          busy_o,
  output logic          cs_o,
  output logic          done_o,
  output logic          hit_o,
  output logic          wide_o,
  output logic          swap_o
);
  acc_st_e       st_q;
  logic [WW-1:0] cnt_q;
  logic          hit_q, wide_q, swap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      hit_q  <= 1'b0;
      wide_q <= 1'b0;
      swap_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (req_valid_i) begin
          hit_q  <= hit_i;
          wide_q <= wide_i;
          swap_q <= swap_i;
          cnt_q  <= ws_i;
          st_q   <= hit_i ? ST_ACC : ST_DONE;
        end
        ST_ACC: begin
          if (cnt_q == '0) st_q <= ST_DONE;
          else             cnt_q <= cnt_q - 1'b1;
        end
        ST_DONE: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = (st_q != ST_IDLE);
  assign cs_o   = (st_q == ST_ACC);
  assign done_o = (st_q == ST_DONE);
  assign hit_o  = hit_q;
  assign wide_o = wide_q;
  assign swap_o = swap_q;
endmodule

// File: rtl/ext_cs_decoder.sv
module ext_cs_decoder
  import ext_cs_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int BL = BASE_LSB,
  parameter int ML = MIN_WIN_LOG2,
  parameter int SW = SIZE_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_we_i,
  input  logic          cfg_sel_i,
  input  logic [AW-1:0] cfg_wdata_i,
  input  logic          req_valid_i,
  input  logic [AW-1:0] req_addr_i,
  output logic          busy_o,
  output logic          cs_o,
  output logic          done_o,
  output logic          hit_o,
  output logic          wide_o,
  output logic          swap_o
);
  logic [AW-BL-1:0] base_hi;
  logic [SW-1:0]    size;
  ctrl_t            ctrl;
  logic             match;

  ext_cs_cfg_regs #(.AW(AW), .BL(BL), .SW(SW)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (cfg_we_i),
    .sel_i     (cfg_sel_i),
    .wdata_i   (cfg_wdata_i),
    .base_hi_o (base_hi),
    .size_o    (size),
    .ctrl_o    (ctrl)
  );

  ext_cs_addr_match #(.AW(AW), .BL(BL), .ML(ML), .SW(SW)) u_match (
    .addr_i    (req_addr_i),
    .base_hi_i (base_hi),
    .size_i    (size),
    .en_i      (ctrl.en),
    .hit_o     (match)
  );

  ext_cs_access_fsm #(.WW(WS_W)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .hit_i       (match),
    .ws_i        (ctrl.ws),
    .wide_i      (ctrl.wide),
    .swap_i      (ctrl.swap),
    .busy_o      (busy_o),
    .cs_o        (cs_o),
    .done_o      (done_o),
    .hit_o       (hit_o),
    .wide_o      (wide_o),
    .swap_o      (swap_o)
  );
endmodule

// File: rtl/ext_cs_decoder_checker.sv
module ext_cs_decoder_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic busy_o,
  input logic cs_o,
  input logic done_o,
  input logic hit_o,
  input logic wide_o,
  input logic swap_o
);
  a_r6_done_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r6_done_after_cs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_o) |-> (done_o && hit_o));

  a_r7_miss_no_cs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !hit_o) |-> !$past(cs_o));

  a_r5_cs_not_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cs_o && done_o));

  a_r9_active_implies_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_o || done_o) |-> busy_o);

  a_r8_attr_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> ($stable(wide_o) && $stable(swap_o)));
endmodule

bind ext_cs_decoder ext_cs_decoder_checker u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .busy_o (busy_o),
  .cs_o   (cs_o),
  .done_o (done_o),
  .hit_o  (hit_o),
  .wide_o (wide_o),
  .swap_o (swap_o)
);

// File: tb/ext_cs_decoder_bench.sv
module ext_cs_decoder_bench;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    bit hit;
    int cs_n;
    int busy_n;
    bit wide;
    bit swap;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic        cfg_sel = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        busy, cs, done, hit, wide, swap;

  int tests = 0;
  int fails = 0;
  int cs_cnt = 0;
  int busy_cnt = 0;
  int done_seen = 0;
  int issued = 0;
  logic [31:0] m_base = '0;
  logic [31:0] m_ctrl = '0;
  item_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  ext_cs_decoder u_ext_cs_decoder (
    .clk_i (clk), .rst_ni (rst_n),
    .cfg_we_i (cfg_we), .cfg_sel_i (cfg_sel), .cfg_wdata_i (cfg_wdata),
    .req_valid_i (req_valid), .req_addr_i (req_addr),
    .busy_o (busy), .cs_o (cs), .done_o (done), .hit_o (hit),
    .wide_o (wide), .swap_o (swap)
  );

  task automatic check(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit model_hit(logic [31:0] a);
    int lg;
    logic [31:0] mask;
    lg   = 13 + int'(m_base[3:0]);
    mask = 32'(~((64'd1 << lg) - 64'd1));
    return m_ctrl[0] && ((a & mask) == (m_base & mask));
  endfunction

  task automatic write_cfg(bit sel, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (sel) m_ctrl = d; else m_base = d;
  endtask

  task automatic issue(logic [31:0] a);
    item_t it;
    @(negedge clk);
    while (busy) @(negedge clk);
    it.hit    = model_hit(a);
    it.cs_n   = it.hit ? 1 + int'(m_ctrl[3:1]) : 0;
    it.busy_n = it.hit ? 2 + int'(m_ctrl[3:1]) : 1;
    it.wide   = m_ctrl[4];
    it.swap   = m_ctrl[10];
    q.push_back(it);
    issued++;
    req_valid = 1'b1; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (cs) cs_cnt++;
      if (busy) busy_cnt++;
      if (done) begin
        done_seen++;
        if (q.size() == 0) begin
          tests++; fails++;
          $display("FAIL R9: actual unexpected done expected none");
        end else begin
          item_t e;
          e = q.pop_front();
          check("R2/R3/R4 hit", int'(hit), int'(e.hit));
          check("R5/R7 cs cycles", cs_cnt, e.cs_n);
          check("R6/R7 busy span", busy_cnt, e.busy_n);
          check("R8/R10 wide", int'(wide), int'(e.wide));
          check("R8/R10 swap", int'(swap), int'(e.swap));
        end
        cs_cnt = 0;
        busy_cnt = 0;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 cs", int'(cs), 0);
    check("R1 done", int'(done), 0);
    check("R1 busy", int'(busy), 0);
    rst_n = 1'b1;
    issue(32'h0000_0000);                // R1 zero config misses
    // R3 8 KB window at 0x2000_0000, ws=2, 16-bit
    write_cfg(1'b0, 32'h2000_0000);
    write_cfg(1'b1, 32'h0000_0015);
    issue(32'h2000_1FFC);
    issue(32'h2000_2000);
    issue(32'h1FFF_FFFC);
    // R3 128 KB window, low base bits ignored
    write_cfg(1'b0, 32'h4002_0004);
    issue(32'h4003_FFFF);
    issue(32'h4004_0000);
    issue(32'h4001_FFFF);
    issue(32'h4002_0000);
    // R4 256 MB window
    write_cfg(1'b0, 32'h2ABC_DE0F);
    issue(32'h2FFF_FFFF);
    issue(32'h2000_0000);
    issue(32'h3000_0000);
    // R5/R8 wait-state sweep with width and swap patterns
    for (int w = 0; w < 8; w++) begin
      write_cfg(1'b1, 32'h1 | (32'(w) << 1) | (32'(w & 1) << 4) | (32'((w >> 1) & 1) << 10));
      issue(32'h2123_4568);
    end
    // R2 disabled range never matches
    write_cfg(1'b1, 32'h0000_041E);
    issue(32'h2000_0000);
    // R9 requests during busy ignored
    write_cfg(1'b1, 32'h0000_0007);
    issue(32'h2000_0000);
    req_valid = 1'b1; req_addr = 32'h2000_0040;
    @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    // R10 config change mid-access
    write_cfg(1'b1, 32'h0000_001F);
    issue(32'h2000_0100);
    write_cfg(1'b1, 32'h0000_0401);
    issue(32'h2000_0200);
    // drain
    for (int i = 0; i < 40 && q.size() != 0; i++) @(negedge clk);
    repeat (5) @(negedge clk);
    check("R6 pending items", q.size(), 0);
    check("R6/R9 done count", done_seen, issued);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule